// File: doc/BRIEF.md
# Predicate Minimum-Index Reduction Unit

This unit collapses the per-element results of a linear processing array into scalar answers. Every element offers one predicate bit and one 16-bit word. In a single pass the unit reports the lowest element number whose predicate is set, how many predicates are set, and one reduced data word. The data word is selected by a mode input. It is either the word held by the first flagged element or the modulo-2^16 total of the words held by all flagged elements.

All elements are presented at once on wide input buses. The operands then climb a binary tree with a register at every level. Each tree node carries a packed record made of an any-set flag, a candidate index, a partial count, a candidate word and a partial sum. A new vector may enter on every clock, and the answers leave log2(N) cycles later.

Top module: `pred_min_reduce`

## Requirements
- R1: Predicate bit i of `in_pred` and word `in_data[i*16 +: 16]` belong to element i. When at least one predicate is set, `out_index` equals the smallest i whose predicate is set.
- R2: `out_found` is 1 exactly when at least one predicate of the sampled vector was set. When none was set, `out_found`, `out_index`, `out_count` and `out_data` are all 0, in both modes.
- R3: `out_count` equals the number of set predicates. It is $clog2(N)+1 bits wide and reaches N when every predicate is set.
- R4: With `in_mode` = 0, `out_data` equals the word of the element reported on `out_index`.
- R5: With `in_mode` = 1, `out_data` equals the sum of the words of all flagged elements, taken modulo 2^16. In either mode, the words of elements whose predicate is clear have no effect on `out_data`.
- R6: The results, and an `out_valid` copy of `in_valid`, appear exactly log2(N) clock cycles after the inputs are sampled. A new vector may be accepted on every cycle.
- R7: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low, asynchronous |
| in_valid | input | 1 | Marks the input vector as meaningful |
| in_mode | input | 1 | 0: first flagged word, 1: sum of flagged words |
| in_pred | input | N | One predicate bit per element |
| in_data | input | N*W | Element words, element i at bits i*W +: W |
| out_valid | output | 1 | Delayed copy of in_valid |
| out_found | output | 1 | At least one predicate was set |
| out_index | output | $clog2(N) | Lowest flagged element |
| out_count | output | $clog2(N)+1 | Number of flagged elements |
| out_data | output | W | Selected word or wrapped sum |

## Verification
The embedded assertions check three things on every cycle. An empty vector yields all-zero results, the count stays within N and is non-zero whenever a match is reported, and a single flag makes the first-word and sum paths agree. These checks cannot show whether the reported index is truly the lowest, or whether the sum and the count are right. They also cannot show whether clear elements leak their words into the result, or whether the latency is exact. The bench establishes those by comparing against a behavioural model. That model runs on directed vectors (empty, full, lowest element alone, highest element alone, two scattered flags) and on a long stream of random back-to-back vectors.

// File: rtl/pred_min_reduce.sv
module pred_min_reduce #(
  parameter int N = 16,
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_mode,
  input  logic [N-1:0]           in_pred,
  input  logic [N*W-1:0]         in_data,
  output logic                   out_valid,
  output logic                   out_found,
  output logic [$clog2(N)-1:0]   out_index,
  output logic [$clog2(N):0]     out_count,
  output logic [W-1:0]           out_data
);
  localparam int IW  = $clog2(N);
  localparam int CW  = IW + 1;
  localparam int LAT = IW;
  localparam int NI  = N - 1;
  localparam int NT  = 2 * N - 1;

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] idx;
    logic [CW-1:0] cnt;
    logic [W-1:0]  word;
    logic [W-1:0]  sum;
  } node_t;

  function automatic node_t join_pair(node_t l, node_t r);
    node_t m;
    m.hit  = l.hit | r.hit;
    m.idx  = l.hit ? l.idx  : r.idx;
    m.word = l.hit ? l.word : r.word;
    m.cnt  = l.cnt + r.cnt;
    m.sum  = l.sum + r.sum;
    return m;
  endfunction

  node_t tree  [NI];
  node_t nodes [NT];
  logic [LAT-1:0] vld_q, mode_q;

  always_comb begin
    for (int k = 0; k < NI; k++) nodes[k] = tree[k];
    for (int i = 0; i < N; i++) begin
      nodes[NI+i].hit  = in_pred[i];
      nodes[NI+i].idx  = IW'(i);
      nodes[NI+i].cnt  = CW'(in_pred[i]);
      nodes[NI+i].word = in_pred[i] ? in_data[i*W +: W] : '0;
      nodes[NI+i].sum  = in_pred[i] ? in_data[i*W +: W] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NI; k++) tree[k] <= '0;
      vld_q  <= '0;
      mode_q <= '0;
    end else begin
      for (int k = 0; k < NI; k++) tree[k] <= join_pair(nodes[2*k+1], nodes[2*k+2]);
      vld_q  <= (vld_q << 1)  | LAT'(in_valid);
      mode_q <= (mode_q << 1) | LAT'(in_mode);
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_found = tree[0].hit;
  assign out_index = tree[0].hit ? tree[0].idx : '0;
  assign out_count = tree[0].cnt;
  assign out_data  = mode_q[LAT-1] ? tree[0].sum : tree[0].word;

  assert_empty_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_found |-> (out_count == '0 && out_index == '0 && out_data == '0));

  assert_found_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_found |-> out_count != '0);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= CW'(N));

  assert_single_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_count == CW'(1)) |-> (tree[0].word == tree[0].sum));
endmodule

// File: tb/pred_min_reduce_tb.sv
module pred_min_reduce_tb;
  localparam int N = 16;
  localparam int W = 16;
  localparam int IW = $clog2(N);
  localparam int LAT = IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_mode = 1'b0;
  logic [N-1:0] in_pred = '0;
  logic [N*W-1:0] in_data = '0;
  logic out_valid, out_found;
  logic [IW-1:0] out_index;
  logic [IW:0] out_count;
  logic [W-1:0] out_data;

  always #5 clk = ~clk;

  pred_min_reduce #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_pred(in_pred), .in_data(in_data), .out_valid(out_valid),
    .out_found(out_found), .out_index(out_index), .out_count(out_count),
    .out_data(out_data));

  typedef struct { int v; int f; int idx; int cnt; int data; bit rst; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t model(bit v, bit m, logic [N-1:0] p, logic [N*W-1:0] d, bit r);
    exp_t e;
    int first = -1;
    int s = 0;
    e.v = v; e.cnt = 0; e.rst = r;
    for (int i = 0; i < N; i++) if (p[i]) begin
      if (first < 0) first = i;
      e.cnt++;
      s = (s + int'(d[i*W +: W])) % 65536;
    end
    e.f = (first >= 0);
    e.idx = (first >= 0) ? first : 0;
    if (m) e.data = s;
    else e.data = (first >= 0) ? int'(d[first*W +: W]) : 0;
    return e;
  endfunction

  task automatic step(bit r, bit v, bit m, logic [N-1:0] p, logic [N*W-1:0] d);
    exp_t e;
    @(negedge clk);
    if (q.size() == LAT) begin
      e = q.pop_front();
      if (e.rst) begin
        chk("R7 valid", out_valid, 0);
        chk("R7 found", out_found, 0);
        chk("R7 count", int'(out_count), 0);
        chk("R7 data", int'(out_data), 0);
      end else begin
        chk("R6 valid", out_valid, e.v);
        chk("R2 found", out_found, e.f);
        chk("R1 index", int'(out_index), e.idx);
        chk("R3 count", int'(out_count), e.cnt);
        chk("R4/R5 data", int'(out_data), e.data);
      end
    end
    rst_n = !r;
    in_valid = v; in_mode = m; in_pred = p; in_data = d;
    q.push_back(model(v, m, p, d, r));
  endtask

  function automatic logic [N*W-1:0] rnd_data();
    logic [N*W-1:0] d;
    for (int i = 0; i < N; i++) d[i*W +: W] = W'($urandom);
    return d;
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] d;
    void'($urandom(7));
    for (int k = 0; k < LAT + 3; k++) step(1, 1, 1, '1, rnd_data());
    d = '1;
    step(0, 1, 0, '0, d);                          // R2 empty, mode 0
    step(0, 1, 1, '0, d);                          // R2 empty, mode 1
    step(0, 1, 0, '1, rnd_data());                 // R3 full count, R1 index 0
    step(0, 1, 1, '1, d);                          // R5 wrap sum, R3 count N
    step(0, 1, 0, 16'h0001, rnd_data());           // R1 lowest alone
    step(0, 1, 0, 16'h8000, rnd_data());           // R1 highest alone
    step(0, 0, 1, 16'h8000, rnd_data());           // R6 valid low
    step(0, 1, 0, 16'h0208, rnd_data());           // R4 first of two
    step(0, 1, 1, 16'h0208, rnd_data());           // R5 sum of two
    for (int k = 0; k < 400; k++) begin
      logic [N-1:0] p;
      p = ((k % 3) == 0) ? N'($urandom) & N'($urandom) & N'($urandom) : N'($urandom);
      step(0, 1'($urandom), 1'($urandom), p, rnd_data());
    end
    for (int k = 0; k < LAT + 1; k++) step(0, 0, 0, '0, rnd_data());
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule